// File: doc/BRIEF.md
# Dual-Port Synchronous Memory with Cross-Port Forwarding

This block is a single-clock memory with two independent ports, X and Y. Each port has its own address, write data, read data, write strobe and output enable, and both share one storage array. Every control and data input is captured on the rising clock edge. The following edge performs the array access and loads the per-port output register. A read therefore returns data on the second edge after its address is presented.

Either port can forward the word it captured straight to the other port's output register, bypassing the array. Forwarding outranks a read, and no array write happens in a cycle that forwards. Same-address conflicts between the ports always resolve the same way: a read sees the contents from before a concurrent write, and when both ports write, port Y's data is the one stored.

The bidirectional data bus is modelled as separate input data, output data and drive-enable signals. The output enables act combinationally and are never registered. The array holds 2^ADDR_W words of DATA_W bits. The default of ADDR_W is kept small for elaboration; a value of 15 gives 32768 words of 36 bits.

Top module: `dpsram_pt`

## Requirements
- R1: After reset, both output registers hold zero, so with an output enable high that port drives zero.
- R2: A read whose address and controls are captured on clock edge N appears on that port's output after edge N+1.
- R3: A port write (write strobe 1) stores its data at its address, and a later read from either port returns it. A port that writes keeps its output register unchanged in that cycle.
- R4: When both ports read the same address in one cycle, both return the stored word.
- R5: When one port writes and the other reads the same address in one cycle, the read returns the old contents. The new word is visible from the next access on.
- R6: When both ports write the same address in one cycle, the array keeps port Y's data.
- R7: With x_pass=1 (and y_pass=0), port Y's output register loads port X's captured input data in place of any array read. Port X still reads normally if its write strobe is 0.
- R8: With y_pass=1 (and x_pass=0), port X's output register loads port Y's captured input data in place of any array read. Port Y still reads normally if its write strobe is 0.
- R9: In a cycle where x_pass or y_pass is 1, no array write occurs, even if write strobes are 1.
- R10: With x_pass=1 and y_pass=1 together, the two ports exchange their captured input data, and the array is untouched.
- R11: The block is selected only when sel_n=0 and sel=1 at capture. When it is not selected, no write occurs and both output registers hold their values.
- R12: Each output enable acts combinationally. With it low, the port's drive-enable is 0 and its data output is zero. With it high, the port's drive-enable is 1 and the output register is presented, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| sel_n | input | 1 | Select, active low, registered |
| sel | input | 1 | Select, active high, registered |
| x_addr | input | ADDR_W | Port X address |
| x_din | input | DATA_W | Port X input data |
| x_wr | input | 1 | Port X write strobe |
| x_pass | input | 1 | Forward port X input data to port Y output |
| x_oe | input | 1 | Port X output enable, combinational |
| x_dout | output | DATA_W | Port X output data (zero when not enabled) |
| x_drive | output | 1 | Port X bus drive enable |
| y_addr | input | ADDR_W | Port Y address |
| y_din | input | DATA_W | Port Y input data |
| y_wr | input | 1 | Port Y write strobe |
| y_pass | input | 1 | Forward port Y input data to port X output |
| y_oe | input | 1 | Port Y output enable, combinational |
| y_dout | output | DATA_W | Port Y output data (zero when not enabled) |
| y_drive | output | 1 | Port Y bus drive enable |

## Verification
The bench steers each port pair onto one address to hit the collision cases. A design that wrote before reading would return the new word on a read-against-write. A design that let X win a dual write would store the wrong word, and the read-back exposes it. Forwarding cycles are given active write strobes and destinations that would otherwise read. A read that beat forwarding shows array data, and a write that slipped through shows up in a later read. Half-selected cycles check that a single select is not enough, and output enables are toggled in the same cycle as they are observed, so a registered enable shows up one cycle late.

// File: rtl/dpsram_pt.sv
module dpsram_pt #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [DATA_W-1:0] x_din,
  input  logic              x_wr,
  input  logic              x_pass,
  input  logic              x_oe,
  output logic [DATA_W-1:0] x_dout,
  output logic              x_drive,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic [DATA_W-1:0] y_din,
  input  logic              y_wr,
  input  logic              y_pass,
  input  logic              y_oe,
  output logic [DATA_W-1:0] y_dout,
  output logic              y_drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              r_sel_n, r_sel;
  logic [ADDR_W-1:0] r_xa, r_ya;
  logic [DATA_W-1:0] r_xd, r_yd;
  logic              r_xwr, r_ywr, r_xpass, r_ypass;
  logic [DATA_W-1:0] xq, yq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sel_n <= 1'b1;
      r_sel   <= 1'b0;
      r_xa    <= '0;
      r_ya    <= '0;
      r_xd    <= '0;
      r_yd    <= '0;
      r_xwr   <= 1'b0;
      r_ywr   <= 1'b0;
      r_xpass <= 1'b0;
      r_ypass <= 1'b0;
    end else begin
      r_sel_n <= sel_n;
      r_sel   <= sel;
      r_xa    <= x_addr;
      r_ya    <= y_addr;
      r_xd    <= x_din;
      r_yd    <= y_din;
      r_xwr   <= x_wr;
      r_ywr   <= y_wr;
      r_xpass <= x_pass;
      r_ypass <= y_pass;
    end
  end

  wire en   = ~r_sel_n & r_sel;
  wire pass = r_xpass | r_ypass;
  wire wr_x = en & r_xwr & ~pass;
  wire wr_y = en & r_ywr & ~pass;

  // Y's write follows X's in this process, so Y wins a dual write
  always_ff @(posedge clk) begin
    if (wr_x) mem[r_xa] <= r_xd;
    if (wr_y) mem[r_ya] <= r_yd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xq <= '0;
      yq <= '0;
    end else if (en) begin
      if (r_ypass)     xq <= r_yd;
      else if (!r_xwr) xq <= mem[r_xa];
      if (r_xpass)     yq <= r_xd;
      else if (!r_ywr) yq <= mem[r_ya];
    end
  end

  assign x_drive = x_oe;
  assign y_drive = y_oe;
  assign x_dout  = x_oe ? xq : '0;
  assign y_dout  = y_oe ? yq : '0;

  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(xq) && $stable(yq))); // R11
  AST_FWD_X_TO_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (en && r_xpass) |=> (yq == $past(r_xd))); // R7
  AST_FWD_Y_TO_X: assert property (@(posedge clk) disable iff (!rst_n)
    (en && r_ypass) |=> (xq == $past(r_yd))); // R8
  AST_PASS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pass) |=> (mem[$past(r_xa)] == $past(mem[r_xa]) && mem[$past(r_ya)] == $past(mem[r_ya]))); // R9
  AST_DUAL_WR_Y_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_x && wr_y && r_xa == r_ya) |=> (mem[$past(r_ya)] == $past(r_yd))); // R6
  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_x && !r_ywr && r_xa == r_ya) |=> (yq == $past(mem[r_ya]))); // R5
endmodule

// File: tb/dpsram_pt_tb.sv
`timescale 1ns/1ps
module dpsram_pt_tb;
  localparam int AW = 10;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sel = 1'b0;
  logic [AW-1:0] x_addr = '0, y_addr = '0;
  logic [DW-1:0] x_din = '0, y_din = '0;
  logic x_wr = 1'b0, y_wr = 1'b0, x_pass = 1'b0, y_pass = 1'b0;
  logic x_oe = 1'b1, y_oe = 1'b1;
  logic [DW-1:0] x_dout, y_dout;
  logic x_drive, y_drive;

  always #2 clk = ~clk;

  dpsram_pt #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel),
    .x_addr(x_addr), .x_din(x_din), .x_wr(x_wr), .x_pass(x_pass), .x_oe(x_oe),
    .x_dout(x_dout), .x_drive(x_drive),
    .y_addr(y_addr), .y_din(y_din), .y_wr(y_wr), .y_pass(y_pass), .y_oe(y_oe),
    .y_dout(y_dout), .y_drive(y_drive)
  );

  typedef struct {
    logic [DW-1:0] x;
    logic [DW-1:0] y;
    string tag;
  } exp_t;

  exp_t q[$];
  logic [DW-1:0] mdl [int];
  logic [DW-1:0] ex = '0, ey = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input bit s_n, input bit s, input int xa, input int ya,
                    input logic [DW-1:0] xd, input logic [DW-1:0] yd,
                    input bit xw, input bit yw, input bit xp, input bit yp,
                    input string tag, input bit xo = 1'b1, input bit yo = 1'b1);
    logic [DW-1:0] nx, ny;
    exp_t it;
    @(negedge clk);
    sel_n = s_n; sel = s; x_addr = AW'(xa); y_addr = AW'(ya);
    x_din = xd; y_din = yd; x_wr = xw; y_wr = yw; x_pass = xp; y_pass = yp;
    x_oe = xo; y_oe = yo;
    nx = ex; ny = ey;
    if (!s_n && s) begin
      if (yp) nx = yd; else if (!xw) nx = mdl[xa];
      if (xp) ny = xd; else if (!yw) ny = mdl[ya];
      if (!xp && !yp) begin
        if (xw) mdl[xa] = xd;
        if (yw) mdl[ya] = yd;
      end
    end
    ex = nx; ey = ny;
    it.x = nx; it.y = ny; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    exp_t it;
    logic [DW-1:0] ax, ay;
    #1;
    if (q.size() > 2) begin
      it = q.pop_front();
      ax = x_oe ? it.x : '0;
      ay = y_oe ? it.y : '0;
      chk(x_dout === ax, {it.tag, " port X"}, x_dout, ax);
      chk(y_dout === ay, {it.tag, " port Y"}, y_dout, ay);
      chk(x_drive === x_oe && y_drive === y_oe, "R12 drive", {34'd0, x_drive, y_drive}, {34'd0, x_oe, y_oe});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(x_dout === '0 && y_dout === '0, "R1 reset X", x_dout, '0);
    chk(y_dout === '0, "R1 reset Y", y_dout, '0);

    // R3 fill: X writes 0..7, Y writes 8..15
    for (int i = 0; i < 8; i++)
      op(0, 1, i, i + 8, DW'(36'h1000 + i), DW'(36'hA_5000_0000 + i), 1, 1, 0, 0, "R3 write");
    // R2/R3 reads, crossing ports
    for (int i = 0; i < 8; i++)
      op(0, 1, i + 8, i, '0, '0, 0, 0, 0, 0, "R2 R3 read");
    // R4 same address, both read
    op(0, 1, 5, 5, '0, '0, 0, 0, 0, 0, "R4 same read");
    op(0, 1, 12, 12, '0, '0, 0, 0, 0, 0, "R4 same read");
    // R5 X writes, Y reads same address, then both read
    op(0, 1, 3, 3, 36'hF_0F0F_0F0F, '0, 1, 0, 0, 0, "R5 read old");
    op(0, 1, 3, 3, '0, '0, 0, 0, 0, 0, "R5 new visible");
    // R5 Y writes, X reads
    op(0, 1, 9, 9, '0, 36'h3_3333_3333, 0, 1, 0, 0, "R5 read old");
    op(0, 1, 9, 9, '0, '0, 0, 0, 0, 0, "R5 new visible");
    // R6 dual write same address
    op(0, 1, 4, 4, 36'h1_1111_1111, 36'h2_2222_2222, 1, 1, 0, 0, "R6 dual write");
    op(0, 1, 4, 4, '0, '0, 0, 0, 0, 0, "R6 Y stored");
    // R7 forward X to Y, X reads, X write strobe ignored (R9)
    op(0, 1, 1, 2, 36'hC_AFE0_0001, '0, 0, 0, 1, 0, "R7 fwd X to Y");
    op(0, 1, 6, 6, 36'hD_EAD0_0006, 36'hB_EEF0_0006, 1, 1, 1, 0, "R9 fwd blocks write");
    op(0, 1, 6, 6, '0, '0, 0, 0, 0, 0, "R9 no write");
    // R8 forward Y to X
    op(0, 1, 7, 10, '0, 36'h7_7700_0077, 0, 0, 0, 1, "R8 fwd Y to X");
    op(0, 1, 11, 11, 36'h5_5555_0000, 36'h6_6666_0000, 1, 1, 0, 1, "R9 fwd blocks write");
    op(0, 1, 11, 11, '0, '0, 0, 0, 0, 0, "R9 no write");
    // R10 swap
    op(0, 1, 0, 8, 36'hA_AAAA_0001, 36'hB_BBBB_0002, 1, 1, 1, 1, "R10 swap");
    op(0, 1, 0, 8, '0, '0, 0, 0, 0, 0, "R10 array untouched");
    // R11 deselect patterns, with writes attempted
    op(0, 1, 1, 1, '0, '0, 0, 0, 0, 0, "R11 baseline");
    op(1, 1, 1, 2, 36'hE_0000_0001, 36'hE_0000_0002, 1, 1, 0, 0, "R11 sel_n high");
    op(0, 0, 1, 2, 36'hE_0000_0003, 36'hE_0000_0004, 1, 1, 0, 0, "R11 sel low");
    op(1, 0, 3, 4, '0, '0, 0, 0, 1, 1, "R11 both off");
    op(0, 1, 1, 2, '0, '0, 0, 0, 0, 0, "R11 no write");
    // R12 output enables toggled
    op(0, 1, 13, 14, '0, '0, 0, 0, 0, 0, "R12 oe", 0, 1);
    op(0, 1, 15, 13, '0, '0, 0, 0, 0, 0, "R12 oe", 1, 0);
    op(0, 1, 5, 7, '0, '0, 0, 0, 0, 0, "R12 oe", 0, 0);
    op(0, 1, 2, 3, '0, '0, 0, 0, 0, 0, "R12 oe", 1, 1);
    // drain
    for (int i = 0; i < 3; i++)
      op(1, 0, 0, 0, '0, '0, 0, 0, 0, 0, "R11 drain");
    @(negedge clk); #2;
    finish_run();
  end
endmodule